// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block derives two banks of divided clocks from one source clock. The source is either a free-running oscillator clock or one of two reference clocks. A reference select picks which reference is used. A source select then chooses between the oscillator and that reference, so the reference can be routed around the oscillator path for test. Each bank has its own 2-bit ratio code and its own table of even ratios. Bank A divides by 2, 4, 6 or 8. Bank B divides by 4, 6, 8 or 12. Each bank drives four identical copies of its divided clock.

A master-disable input does two things at once. It clears the counters of both banks asynchronously. It also pulls every output enable low, so the pad ring tri-states the outputs. While it is held, the outputs carry a low level. When it is released, both banks start counting from zero on the same source edge. This gives the two banks a common phase origin.

The selects are static configuration. They change only while the block is disabled.

Top module: `clkdiv_dual_bank`

## Requirements
- R1: With `div_sel_a` = 0, 1, 2, 3, bank A produces a clock whose period is 2, 4, 6 or 8 source cycles.
- R2: With `div_sel_b` = 0, 1, 2, 3, bank B produces a clock whose period is 4, 6, 8 or 12 source cycles.
- R3: Each divided clock is high for exactly half of its period, measured in source cycles.
- R4: While `mr_dis` is 1, all eight output enables and all eight data outputs are 0 and the counters are cleared. This takes effect at once, with no source edge needed.
- R5: After `mr_dis` falls, both banks read 0. A bank with ratio N first rises right after the (N/2)-th source rising edge following the release, and both banks count from that same edge.
- R6: With `osc_sel` = 1 the dividers count `osc_clk`. With `osc_sel` = 0 they count the selected reference clock directly.
- R7: With `ref_sel` = 0 the selected reference is `ref_clk_1`. With `ref_sel` = 1 it is `ref_clk_2`.
- R8: The four outputs of a bank are always equal to one another.
- R9: While `mr_dis` is 0, all eight output enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock |
| ref_clk_1 | input | 1 | First reference clock |
| ref_clk_2 | input | 1 | Second reference clock |
| ref_sel | input | 1 | Reference pick: 0 first, 1 second |
| osc_sel | input | 1 | Source pick: 1 oscillator, 0 reference bypass |
| mr_dis | input | 1 | Master reset and output disable, active high |
| div_sel_a | input | 2 | Bank A ratio code |
| div_sel_b | input | 2 | Bank B ratio code |
| q_a | output | 4 | Bank A clock copies |
| q_a_en | output | 4 | Bank A pad output enables |
| q_b | output | 4 | Bank B clock copies |
| q_b_en | output | 4 | Bank B pad output enables |

## Verification
A counter that is off by one, or that starts from a stale value, moves the first rising edge after release. That error shows on the first output period, within at most twelve source edges, so the bench compares every source cycle from the release onward. A wrong table entry or a wrong source mux shows as a period or high-time mismatch within one period, because the two reference clocks and the oscillator run at unrelated rates. A disable path that waits for an edge leaves an enable high one nanosecond after `mr_dis` rises, and that is visible at once.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   localparam int unsigned SEL_W   = 2;
   localparam int unsigned N_CODES = 1 << SEL_W;

   // Half-period tables, in source cycles, indexed by ratio code
   typedef int unsigned half_tbl_t [N_CODES];

   localparam half_tbl_t BANK_A_HALF = '{1, 2, 3, 4};
   localparam half_tbl_t BANK_B_HALF = '{2, 3, 4, 6};

   typedef enum logic {
      SRC_REFERENCE  = 1'b0,
      SRC_OSCILLATOR = 1'b1
   } src_kind_e;

   function automatic int unsigned tbl_max(half_tbl_t t);
      int unsigned m;
      m = 0;
      for (int i = 0; i < N_CODES; i++) begin
         if (t[i] > m) m = t[i];
      end
      return m;
   endfunction

   function automatic int unsigned cnt_width(int unsigned max_half);
      return (max_half < 2) ? 1 : $clog2(max_half);
   endfunction

endpackage

// File: rtl/clkdiv_src_sel.sv
module clkdiv_src_sel (
   input  logic osc_clk,
   input  logic ref_clk_1,
   input  logic ref_clk_2,
   input  logic ref_sel,
   input  logic osc_sel,
   output logic src_clk
);
   import clkdiv_pkg::*;

   logic      ref_pick;
   src_kind_e kind;

   // Selects are static while the block runs; glitches occur only under reset.
   always_comb begin
      ref_pick = ref_sel ? ref_clk_2 : ref_clk_1;
      kind     = src_kind_e'(osc_sel);
      case (kind)
         SRC_OSCILLATOR: src_clk = osc_clk;
         default:        src_clk = ref_pick;
      endcase
   end

endmodule

// File: rtl/clkdiv_ratio_div.sv
module clkdiv_ratio_div #(
   parameter clkdiv_pkg::half_tbl_t HALF_TBL = clkdiv_pkg::BANK_A_HALF
) (
   input  logic                         src_clk,
   input  logic                         clr,
   input  logic [clkdiv_pkg::SEL_W-1:0] div_sel,
   output logic                         div_clk
);
   import clkdiv_pkg::*;

   localparam int unsigned MAX_HALF = tbl_max(HALF_TBL);
   localparam int unsigned CNT_W    = cnt_width(MAX_HALF);

   for (genvar g = 0; g < N_CODES; g++) begin : g_tbl_check
      if (HALF_TBL[g] == 0) begin : g_bad
         $error("half-period table entry %0d is zero", g);
      end
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic             wrap;

   always_comb begin
      limit = CNT_W'(HALF_TBL[div_sel] - 1);
      wrap  = (cnt == limit);
   end

   always_ff @(posedge src_clk or posedge clr) begin
      if (clr) begin
         cnt     <= '0;
         div_clk <= 1'b0;
      end else if (wrap) begin
         cnt     <= '0;
         div_clk <= ~div_clk;
      end else begin
         cnt     <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/clkdiv_fanout.sv
module clkdiv_fanout #(
   parameter int unsigned FANOUT = 4
) (
   input  logic              div_clk,
   input  logic              disable_all,
   output logic [FANOUT-1:0] q,
   output logic [FANOUT-1:0] q_en
);

   initial begin
      if (FANOUT < 1) $error("FANOUT must be at least 1");
   end

   for (genvar g = 0; g < FANOUT; g++) begin : g_copy
      assign q[g]    = div_clk & ~disable_all;
      assign q_en[g] = ~disable_all;
   end

endmodule

// File: rtl/clkdiv_dual_bank.sv
module clkdiv_dual_bank #(
   parameter int unsigned FANOUT = 4
) (
   input  logic                         osc_clk,
   input  logic                         ref_clk_1,
   input  logic                         ref_clk_2,
   input  logic                         ref_sel,
   input  logic                         osc_sel,
   input  logic                         mr_dis,
   input  logic [clkdiv_pkg::SEL_W-1:0] div_sel_a,
   input  logic [clkdiv_pkg::SEL_W-1:0] div_sel_b,
   output logic [FANOUT-1:0]            q_a,
   output logic [FANOUT-1:0]            q_a_en,
   output logic [FANOUT-1:0]            q_b,
   output logic [FANOUT-1:0]            q_b_en
);
   import clkdiv_pkg::*;

   logic src_clk;
   logic div_a;
   logic div_b;

   clkdiv_src_sel u_src (
      .osc_clk  (osc_clk),
      .ref_clk_1(ref_clk_1),
      .ref_clk_2(ref_clk_2),
      .ref_sel  (ref_sel),
      .osc_sel  (osc_sel),
      .src_clk  (src_clk)
   );

   clkdiv_ratio_div #(.HALF_TBL(BANK_A_HALF)) u_div_a (
      .src_clk(src_clk),
      .clr    (mr_dis),
      .div_sel(div_sel_a),
      .div_clk(div_a)
   );

   clkdiv_ratio_div #(.HALF_TBL(BANK_B_HALF)) u_div_b (
      .src_clk(src_clk),
      .clr    (mr_dis),
      .div_sel(div_sel_b),
      .div_clk(div_b)
   );

   clkdiv_fanout #(.FANOUT(FANOUT)) u_out_a (
      .div_clk    (div_a),
      .disable_all(mr_dis),
      .q          (q_a),
      .q_en       (q_a_en)
   );

   clkdiv_fanout #(.FANOUT(FANOUT)) u_out_b (
      .div_clk    (div_b),
      .disable_all(mr_dis),
      .q          (q_b),
      .q_en       (q_b_en)
   );

endmodule

// File: rtl/clkdiv_dual_bank_chk.sv
module clkdiv_dual_bank_chk #(
   parameter int unsigned FANOUT = 4
) (
   input logic              src_clk,
   input logic              osc_clk,
   input logic              mr_dis,
   input logic [1:0]        div_sel_a,
   input logic [1:0]        div_sel_b,
   input logic [FANOUT-1:0] q_a,
   input logic [FANOUT-1:0] q_a_en,
   input logic [FANOUT-1:0] q_b,
   input logic [FANOUT-1:0] q_b_en
);

   // Independent half-period view of the ratio codes
   function automatic logic [7:0] half_of_a(logic [1:0] s);
      case (s)
         2'd0: return 8'd1;
         2'd1: return 8'd2;
         2'd2: return 8'd3;
         default: return 8'd4;
      endcase
   endfunction

   function automatic logic [7:0] half_of_b(logic [1:0] s);
      case (s)
         2'd0: return 8'd2;
         2'd1: return 8'd3;
         2'd2: return 8'd4;
         default: return 8'd6;
      endcase
   endfunction

   logic       prev_a, prev_b;
   logic [7:0] run_a, run_b;

   always_ff @(posedge src_clk or posedge mr_dis) begin
      if (mr_dis) begin
         prev_a <= 1'b0;
         prev_b <= 1'b0;
         run_a  <= '0;
         run_b  <= '0;
      end else begin
         prev_a <= q_a[0];
         prev_b <= q_b[0];
         run_a  <= (q_a[0] != prev_a) ? 8'd1 : run_a + 8'd1;
         run_b  <= (q_b[0] != prev_b) ? 8'd1 : run_b + 8'd1;
      end
   end

   // R1 R3: every bank A level lasts exactly half its ratio
   a_r1_a_half_period: assert property (@(posedge src_clk) disable iff (mr_dis)
      (q_a[0] != prev_a) |-> (run_a == half_of_a(div_sel_a)));

   // R2 R3: every bank B level lasts exactly half its ratio
   a_r2_b_half_period: assert property (@(posedge src_clk) disable iff (mr_dis)
      (q_b[0] != prev_b) |-> (run_b == half_of_b(div_sel_b)));

   // R5: first source edge after release sees both banks low
   a_r5_low_after_release: assert property (@(posedge src_clk) disable iff (mr_dis)
      $past(mr_dis) |-> (q_a == '0 && q_b == '0));

   // R8: replicas agree
   a_r8_replicas_equal: assert property (@(posedge src_clk) disable iff (mr_dis)
      (q_a == {FANOUT{q_a[0]}}) && (q_b == {FANOUT{q_b[0]}}));

   // R9: enables up while running
   a_r9_enabled_running: assert property (@(posedge osc_clk) disable iff (mr_dis)
      (&q_a_en) && (&q_b_en));

   // R4: disabled state seen on the free-running clock
   always @(posedge osc_clk) begin
      if (mr_dis) begin
         a_r4_disabled_quiet: assert (q_a_en == '0 && q_b_en == '0 && q_a == '0 && q_b == '0);
      end
   end

endmodule

bind clkdiv_dual_bank clkdiv_dual_bank_chk #(.FANOUT(FANOUT)) u_chk (
   .src_clk  (src_clk),
   .osc_clk  (osc_clk),
   .mr_dis   (mr_dis),
   .div_sel_a(div_sel_a),
   .div_sel_b(div_sel_b),
   .q_a      (q_a),
   .q_a_en   (q_a_en),
   .q_b      (q_b),
   .q_b_en   (q_b_en)
);

// File: tb/clkdiv_dual_bank_bench.sv
`timescale 1ns/1ps
module clkdiv_dual_bank_bench;

   logic osc_clk = 1'b0;
   logic ref_clk_1 = 1'b0;
   logic ref_clk_2 = 1'b0;
   logic ref_sel = 1'b0;
   logic osc_sel = 1'b1;
   logic mr_dis = 1'b1;
   logic [1:0] div_sel_a = 2'd0;
   logic [1:0] div_sel_b = 2'd0;
   logic [3:0] q_a, q_a_en, q_b, q_b_en;

   always #10 osc_clk = ~osc_clk;     // 50 MHz
   always #17 ref_clk_1 = ~ref_clk_1;
   always #23 ref_clk_2 = ~ref_clk_2;

   // Bench's own view of which clock the dividers should count (R6 R7)
   wire tb_src = osc_sel ? osc_clk : (ref_sel ? ref_clk_2 : ref_clk_1);

   clkdiv_dual_bank u_clkdiv_dual_bank (
      .osc_clk  (osc_clk),
      .ref_clk_1(ref_clk_1),
      .ref_clk_2(ref_clk_2),
      .ref_sel  (ref_sel),
      .osc_sel  (osc_sel),
      .mr_dis   (mr_dis),
      .div_sel_a(div_sel_a),
      .div_sel_b(div_sel_b),
      .q_a      (q_a),
      .q_a_en   (q_a_en),
      .q_b      (q_b),
      .q_b_en   (q_b_en)
   );

   int n_chk = 0;
   int n_fail = 0;

   function automatic int ratio_a(logic [1:0] s);
      case (s) 2'd0: return 2; 2'd1: return 4; 2'd2: return 6; default: return 8; endcase
   endfunction

   function automatic int ratio_b(logic [1:0] s);
      case (s) 2'd0: return 4; 2'd1: return 6; 2'd2: return 8; default: return 12; endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_disabled(input string ctx);
      check(q_a_en == 4'h0 && q_b_en == 4'h0, "R4", {ctx, " enables"},
            int'({q_a_en, q_b_en}), 0);
      check(q_a == 4'h0 && q_b == 4'h0, "R4", {ctx, " data"}, int'({q_a, q_b}), 0);
   endtask

   // Configure under reset, release on a source low phase, then compare every cycle
   task automatic run_cfg(input logic os, input logic rs, input logic [1:0] sa,
                          input logic [1:0] sb, input bit cut_short);
      int ha, hb, len;
      int bad_a, bad_b, bad_rep, k_a, k_b, act_a, act_b;
      string ctx;
      mr_dis = 1'b1;
      osc_sel = os; ref_sel = rs; div_sel_a = sa; div_sel_b = sb;
      #60;
      ctx = $sformatf("osc_sel=%0d ref_sel=%0d sa=%0d sb=%0d", os, rs, sa, sb);
      check_disabled(ctx);
      @(negedge tb_src);
      #1 mr_dis = 1'b0;
      #1;
      check(q_a_en == 4'hF && q_b_en == 4'hF, "R9", ctx, int'({q_a_en, q_b_en}), 8'hFF);
      check(q_a == 4'h0 && q_b == 4'h0, "R5 low at release", ctx, int'({q_a, q_b}), 0);
      ha = ratio_a(sa) / 2;
      hb = ratio_b(sb) / 2;
      len = cut_short ? 9 : 3 * ratio_b(sb) + 2;
      bad_a = 0; bad_b = 0; bad_rep = 0; k_a = 0; k_b = 0; act_a = 0; act_b = 0;
      for (int k = 1; k <= len; k++) begin
         @(posedge tb_src);
         @(negedge tb_src);
         #1;
         if (q_a[0] != 1'((k / ha) % 2) && bad_a == 0) begin
            bad_a = 1; k_a = k; act_a = q_a[0];
         end
         if (q_b[0] != 1'((k / hb) % 2) && bad_b == 0) begin
            bad_b = 1; k_b = k; act_b = q_b[0];
         end
         if (q_a != {4{q_a[0]}} || q_b != {4{q_b[0]}}) bad_rep++;
      end
      // R1 R3 R5 R6 R7: bank A waveform, cycle by cycle from release
      check(bad_a == 0, "R1 R3 R5 R6 R7",
            $sformatf("%s bank A level after source edge %0d", ctx, k_a),
            act_a, 1 - act_a);
      // R2 R3 R5 R6 R7: bank B waveform
      check(bad_b == 0, "R2 R3 R5 R6 R7",
            $sformatf("%s bank B level after source edge %0d", ctx, k_b),
            act_b, 1 - act_b);
      check(bad_rep == 0, "R8", {ctx, " replica mismatches"}, bad_rep, 0);
      if (cut_short) begin
         // R4: disable mid-period takes effect without a source edge
         #2 mr_dis = 1'b1;
         #1 check_disabled({ctx, " mid-run"});
      end
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic os, rs;
      void'($urandom(32'h5EED_0C1C));
      #5;
      check_disabled("reset state");
      // All 16 code pairs, sources from the seeded stream
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            os = 1'($urandom % 2);
            rs = 1'($urandom % 2);
            run_cfg(os, rs, 2'(a), 2'(b), 1'b0);
         end
      end
      // Directed: every source path explicitly (R6 R7)
      run_cfg(1'b1, 1'b0, 2'd0, 2'd3, 1'b0);
      run_cfg(1'b0, 1'b0, 2'd1, 2'd1, 1'b0);
      run_cfg(1'b0, 1'b1, 2'd3, 2'd0, 1'b0);
      run_cfg(1'b1, 1'b1, 2'd2, 2'd2, 1'b0);
      // Mid-run disable, then restart in a new configuration (R4 R5)
      run_cfg(1'b1, 1'b0, 2'd3, 2'd3, 1'b1);
      run_cfg(1'b0, 1'b1, 2'd2, 2'd3, 1'b1);
      // Random extra configurations
      for (int i = 0; i < 10; i++) begin
         run_cfg(1'($urandom % 2), 1'($urandom % 2), 2'($urandom % 4),
                 2'($urandom % 4), 1'($urandom % 2));
      end
      mr_dis = 1'b1;
      #40 check_disabled("final disable");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule